// File: doc/BRIEF.md
# Paged SRAM Bank and Lane Selector

This block connects a processor that has a 16-bit address bus and a 24-bit data bus to a 1M-word by 32-bit accumulation SRAM. Each of the two 512K banks of the SRAM is split into two lanes. The low lane holds bits 23..0 and the high lane holds bits 31..24. Software writes a 4-bit page register, and the block places that register above the processor address to form a 20-bit SRAM address. The top page bit chooses the bank. The block drives one active-low chip enable per bank and lane.

The lowest 256 processor addresses belong to internal memory and never reach the SRAM. In 24-bit mode every SRAM access goes to the low lane. In 32-bit mode a one-bit lane pointer sends successive accesses alternately to the low lane and then the high lane. This lets software read or write a full 32-bit word in two bus cycles at the same address. The high lane is carried on the low byte of the processor data bus.

Three control writes manage the block: one loads the page register, one sets the mode, and one clears the lane pointer.

Top module: `sram_page_lane_sel`

## Requirements
- R1: After reset the page is 0, the mode is 24-bit and the lane pointer is on the low lane. With `cpu_strobe` low, all four chip enables, `sram_we_n` and `sram_oe_n` are high.
- R2: A strobed access to an address below 0x0100 asserts no chip enable, `sram_we_n` or `sram_oe_n`. It returns 0 on `cpu_rdata` and does not move the lane pointer.
- R3: `sram_addr` equals {page, cpu_addr}. The page is loaded from `ctl_data[3:0]` by a control write with `ctl_sel` = 0.
- R4: Page bit 3 selects the bank. `sram_ce_n` bit 0 is bank 0 low lane, bit 1 is bank 0 high lane, bit 2 is bank 1 low lane and bit 3 is bank 1 high lane. At most one enable is low at a time.
- R5: In 24-bit mode every in-window access enables the low lane of the selected bank.
- R6: In 32-bit mode the first in-window access after a pointer clear uses the low lane. Each in-window access then flips the lane.
- R7: A control write with `ctl_sel` = 2 returns the lane pointer to the low lane. If an access happens in the same cycle, that access uses the current lane and the next access uses the low lane.
- R8: A control write with `ctl_sel` = 1 sets the mode from `ctl_data[0]` (0 = 24-bit, 1 = 32-bit) and clears the lane pointer. A control write with `ctl_sel` = 3 has no effect.
- R9: Write data: `sram_wdata[23:0]` carries `cpu_wdata`, and `sram_wdata[31:24]` carries `cpu_wdata[7:0]`. An in-window read returns `sram_rdata[23:0]` on the low lane and {16'b0, `sram_rdata[31:24]`} on the high lane. `cpu_rdata` is 0 whenever no in-window read is in progress.
- R10: During an in-window access, `sram_we_n` is low for a write and `sram_oe_n` is low for a read. The other one stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_strobe | input | 1 | One-cycle access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 24 | Processor write data |
| cpu_rdata | output | 24 | Processor read data |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 2 | 0 page, 1 mode, 2 pointer clear, 3 none |
| ctl_data | input | 4 | Control write data |
| sram_addr | output | 20 | SRAM word address |
| sram_ce_n | output | 4 | Chip enables, per bank and lane |
| sram_we_n | output | 1 | SRAM write enable |
| sram_oe_n | output | 1 | SRAM output enable |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data |

## Verification
A lane pointer in the wrong state shows up on the very next in-window access. The wrong one of the two enables for the bank drops, and a 32-bit read then returns the low word where the high byte was expected. A wrong page register shows at once on `sram_addr` and moves the enable to the other bank. Internal-window accesses that disturb the pointer only show on the next SRAM access, so the bench places such accesses between the two halves of a 32-bit pair.

// File: rtl/sram_page_lane_sel.sv
module sram_page_lane_sel #(
  parameter int AW     = 16,
  parameter int DW     = 24,
  parameter int PW     = 4,
  parameter int HW     = 8,
  parameter int WIN_LO = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_strobe,
  input  logic             cpu_we,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_sel,
  input  logic [PW-1:0]    ctl_data,
  output logic [AW+PW-1:0] sram_addr,
  output logic [3:0]       sram_ce_n,
  output logic             sram_we_n,
  output logic             sram_oe_n,
  output logic [DW+HW-1:0] sram_wdata,
  input  logic [DW+HW-1:0] sram_rdata
);
  localparam int MW = DW + HW;
  localparam int NBANK = 2;
  localparam int NLANE = 2;
  localparam logic [AW-1:0] WIN = WIN_LO[AW-1:0];
  localparam logic [1:0] SEL_PAGE = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  logic [PW-1:0] page_q;
  logic          mode_q;
  logic          ptr_q;

  wire hit     = cpu_strobe && (cpu_addr >= WIN);
  wire bank    = page_q[PW-1];
  wire lane_hi = mode_q && ptr_q;
  wire ptr_rst = ctl_we && (ctl_sel == SEL_MODE || ctl_sel == SEL_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= 1'b0;
      ptr_q  <= 1'b0;
    end else begin
      if (ctl_we && ctl_sel == SEL_PAGE) page_q <= ctl_data;
      if (ctl_we && ctl_sel == SEL_MODE) mode_q <= ctl_data[0];
      if (ptr_rst)
        ptr_q <= 1'b0;
      else if (hit && mode_q)
        ptr_q <= ~ptr_q;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign sram_ce_n[b*NLANE+l] = ~(hit && (bank == 1'(b)) && (lane_hi == 1'(l)));
    end
  end

  assign sram_addr  = {page_q, cpu_addr};
  assign sram_we_n  = ~(hit && cpu_we);
  assign sram_oe_n  = ~(hit && !cpu_we);
  assign sram_wdata = {cpu_wdata[HW-1:0], cpu_wdata};
  assign cpu_rdata  = !(hit && !cpu_we) ? '0 :
                      lane_hi ? {{(DW-HW){1'b0}}, sram_rdata[MW-1 -: HW]} :
                      sram_rdata[DW-1:0];
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int AW     = 16,
  parameter int DW     = 24,
  parameter int HW     = 8,
  parameter int WIN_LO = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_strobe,
  input logic          cpu_we,
  input logic [DW-1:0] cpu_rdata,
  input logic          ctl_we,
  input logic [1:0]    ctl_sel,
  input logic [3:0]    sram_ce_n,
  input logic          mode_q,
  input logic          ptr_q
);
  wire inwin = cpu_strobe && (cpu_addr >= WIN_LO[AW-1:0]);

  a_r2_internal_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe && !inwin) |-> (&sram_ce_n && cpu_rdata == '0));

  a_r4_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sram_ce_n));

  a_r5_narrow_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (sram_ce_n[1] && sram_ce_n[3]));

  a_r6_lane_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (inwin && mode_q && !ctl_we) |=> (ptr_q != $past(ptr_q)));

  a_r7_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_sel == 2'd2) |=> !ptr_q);

  a_r9_high_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inwin && !cpu_we && !(sram_ce_n[1] && sram_ce_n[3])) |-> (cpu_rdata[DW-1:HW] == '0));
endmodule

bind sram_page_lane_sel sram_lane_chk #(.AW(AW), .DW(DW), .HW(HW), .WIN_LO(WIN_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_strobe(cpu_strobe),
  .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
  .sram_ce_n(sram_ce_n), .mode_q(mode_q), .ptr_q(ptr_q)
);

// File: tb/test_sram_page_lane_sel.sv
module test_sram_page_lane_sel;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic cpu_strobe = 0, cpu_we = 0;
  logic [23:0] cpu_wdata = 0, cpu_rdata;
  logic ctl_we = 0;
  logic [1:0] ctl_sel = 0;
  logic [3:0] ctl_data = 0;
  logic [19:0] sram_addr;
  logic [3:0] sram_ce_n;
  logic sram_we_n, sram_oe_n;
  logic [31:0] sram_wdata, sram_rdata = 0;

  sram_page_lane_sel i_sram_page_lane_sel (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] page_m = 0;
  logic mode_m = 0, ptr_m = 0;
  logic [31:0] mem [int];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  function automatic logic [3:0] exp_ce(logic hit);
    int idx = page_m[3] * 2 + int'(mode_m & ptr_m);
    return hit ? 4'(~(4'b1 << idx)) : 4'hF;
  endfunction

  task automatic access(logic [15:0] a, logic we, logic [23:0] wd, logic clr = 0);
    logic hit = a >= 16'h0100;
    logic hi = mode_m & ptr_m;
    logic [19:0] sa = {page_m, a};
    logic [31:0] w;
    @(negedge clk);
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_strobe = 1;
    ctl_we = clr; ctl_sel = 2'd2;
    sram_rdata = rd(sa);
    #1;
    chk("R3 addr", 32'(sram_addr), 32'(sa));
    chk(hit ? (mode_m ? "R6 ce" : "R5 ce") : "R2 ce", 32'(sram_ce_n), 32'(exp_ce(hit)));
    chk("R10 we_n/oe_n", {30'b0, sram_we_n, sram_oe_n}, {30'b0, !(hit && we), !(hit && !we)});
    if (hit && we) begin
      if (hi) chk("R9 wdata hi", 32'(sram_wdata[31:24]), 32'(wd[7:0]));
      else    chk("R9 wdata lo", 32'(sram_wdata[23:0]), 32'(wd));
    end
    chk(hit ? "R9 rdata" : "R2 rdata", 32'(cpu_rdata),
        !(hit && !we) ? 32'h0 : hi ? 32'(rd(sa)[31:24]) : 32'(rd(sa)[23:0]));
    @(posedge clk);
    if (hit && we) begin
      w = rd(sa);
      if (hi) w[31:24] = wd[7:0]; else w[23:0] = wd;
      mem[int'(sa)] = w;
    end
    if (clr) ptr_m = 0;
    else if (hit && mode_m) ptr_m = ~ptr_m;
    #1 cpu_strobe = 0; ctl_we = 0;
  endtask

  task automatic ctl(logic [1:0] sel, logic [3:0] d);
    @(negedge clk);
    ctl_we = 1; ctl_sel = sel; ctl_data = d;
    @(posedge clk);
    case (sel)
      2'd0: page_m = d;
      2'd1: begin mode_m = d[0]; ptr_m = 0; end
      2'd2: ptr_m = 0;
      default: ;
    endcase
    #1 ctl_we = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ce idle", 32'(sram_ce_n), 32'hF);
    chk("R1 we/oe idle", {30'b0, sram_we_n, sram_oe_n}, 32'h3);
    rst_n = 1;
    access(16'h1234, 1, 24'hABCDEF);            // R1 reset page 0, bank 0 low
    access(16'h1234, 0, 0);
    access(16'h0042, 0, 0);                     // R2 internal
    ctl(2'd0, 4'h9);                            // R3 R4 bank 1
    access(16'hFFFF, 1, 24'h111111);
    ctl(2'd1, 4'h1);                            // R8 32-bit mode
    access(16'h0200, 1, 24'h0000AA);            // R6 low
    access(16'h00FF, 1, 24'h0);                 // R2 no advance
    access(16'h0200, 1, 24'h123456);            // R6 high
    access(16'h0200, 0, 0);
    access(16'h0200, 0, 0);
    access(16'h0300, 1, 24'h1, 1);              // R7 clear with access
    access(16'h0300, 0, 0);                     // next is low
    ctl(2'd3, 4'h0);                            // R8 no effect
    access(16'h0300, 0, 0);
    ctl(2'd2, 4'h0);                            // R7 clear
    access(16'h0300, 0, 0);
    ctl(2'd1, 4'h1);                            // R8 rewrite clears
    access(16'h0300, 0, 0);
    ctl(2'd1, 4'h0);                            // R5 narrow
    access(16'h0300, 0, 0);
    access(16'h0300, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 6) ctl(2'($urandom_range(0, 3)), 4'($urandom));
      else access(r < 20 ? 16'($urandom_range(0, 255)) : 16'($urandom_range(256, 65535)),
                  1'($urandom), 24'($urandom), r > 96);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule